// File: doc/BRIEF.md
# ECC Write-Path Check-Byte Corruptor

This block sits between the ECC encoder and the memory write port. In normal use it passes the encoder's 8 check bits through unchanged. For testing the error-reporting path, software programs an 8-bit XOR mask and an optional writeback flag, then sets a one-shot trigger. The next memory write leaves with its check byte XORed with the mask. After that write the block disarms itself and returns to pass-through.

The mask picks the kind of fault the decoder will see on read-back. To make a single-bit correctable error in data bit i, software loads that bit's column syndrome. To make one in check bit j, it loads a mask with only bit j set. To make an uncorrectable error, it loads 0x03 with writeback clear. Valid targets are data bits 0 to 63 and check bits 0 to 7. The block also reports a busy flag while writes are still in flight. Software must see that flag clear before it arms an injection.

Top module: `ecc_inj_top`

## Requirements
- R1: After reset the control read-back is zero, the busy flag is low and check bits pass through unchanged.
- R2: While the injector is not armed, `chkOut` equals `chkIn` on every cycle, with or without a write.
- R3: A control write taken while disarmed loads the mask from bits [23:16], the writeback flag from bit 24 and the trigger from bit 8. All three read back at the same positions on the next cycle.
- R4: On the first memory write after arming, `chkOut` equals `chkIn` XOR the mask in that same cycle.
- R5: The trigger clears itself after the injected write. Its read-back bit 8 is zero on the next cycle, and later writes pass through unchanged.
- R6: Control writes made while armed are ignored. The mask, the writeback flag and the trigger keep their values until the injection completes.
- R7: `wbOut` is high only during the injected write, and only when the writeback flag was set.
- R8: The busy flag is high while the count of issued but not yet written transfers is non-zero. An issue and a write in the same cycle leave the count unchanged.
- R9: A memory write in the same cycle as the arming control write is not corrupted. The arming takes effect from the next cycle.
- R10: A control write with bit 8 clear loads the mask but corrupts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 32 | Control register write data |
| ctrlRdData | output | 32 | Control register read-back (mask, writeback, trigger) |
| wrIssue | input | 1 | A write was accepted upstream and is now pending |
| memWrValid | input | 1 | Write to memory happens this cycle |
| chkIn | input | 8 | Check byte from the encoder |
| chkOut | output | 8 | Check byte sent to memory |
| wbOut | output | 1 | Writeback request that goes with an injected write |
| statusBusy | output | 1 | Writes pending (status bit 0) |

## Verification
Two events can land in the same cycle: a control write that arms the injector, and a memory write. The stimulus table drives both in one cycle. It expects that write to pass through clean and the following write to carry the mask. A control write is also driven in the cycle where the armed injection completes, and the read-back must show that it was dropped. Issue and drain of pending writes are likewise made to coincide, and the busy flag must hold steady through that cycle.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef struct packed {
    logic loadCfg;  // accept a control write into the mask
    logic apply;    // corrupt the write in flight this cycle
  } injStrobe_t;
endpackage

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int WB_BIT   = 24,
  parameter int TRIG_BIT = 8,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              wrIssue,
  input  logic              memWrValid,
  output injStrobe_t        strb,
  output logic              armedQ,
  output logic              wbQ,
  output logic              busy,
  output logic              wbOut
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pendCnt;
  logic incPend;
  logic decPend;

  always_comb begin
    strb.loadCfg = ctrlWrEn && !armedQ;
    strb.apply   = memWrValid && armedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      wbQ    <= 1'b0;
    end else if (strb.apply) begin
      armedQ <= 1'b0;
    end else if (strb.loadCfg) begin
      armedQ <= ctrlWrData[TRIG_BIT];
      wbQ    <= ctrlWrData[WB_BIT];
    end
  end

  assign incPend = wrIssue && (pendCnt != PEND_MAX);
  assign decPend = memWrValid && (pendCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      unique case ({incPend, decPend})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  assign busy  = (pendCnt != '0);
  assign wbOut = strb.apply && wbQ;
endmodule

// File: rtl/ecc_inj_datapath.sv
module ecc_inj_datapath
  import ecc_inj_pkg::*;
#(
  parameter int CTRL_W  = 32,
  parameter int CHK_W   = 8,
  parameter int PAT_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  injStrobe_t        strb,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic [CHK_W-1:0]  chkIn,
  output logic [CHK_W-1:0]  chkOut,
  output logic [CHK_W-1:0]  patQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patQ <= '0;
    end else if (strb.loadCfg) begin
      patQ <= ctrlWrData[PAT_LSB +: CHK_W];
    end
  end

  assign chkOut = strb.apply ? (chkIn ^ patQ) : chkIn;
endmodule

// File: rtl/ecc_inj_top.sv
module ecc_inj_top
  import ecc_inj_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int CHK_W    = 8,
  parameter int PAT_LSB  = 16,
  parameter int WB_BIT   = 24,
  parameter int TRIG_BIT = 8,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic              wrIssue,
  input  logic              memWrValid,
  input  logic [CHK_W-1:0]  chkIn,
  output logic [CHK_W-1:0]  chkOut,
  output logic              wbOut,
  output logic              statusBusy
);
  injStrobe_t       strb;
  logic             armedQ;
  logic             wbQ;
  logic [CHK_W-1:0] patQ;

  ecc_inj_ctrl #(
    .CTRL_W(CTRL_W), .WB_BIT(WB_BIT), .TRIG_BIT(TRIG_BIT), .PEND_W(PEND_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .wrIssue(wrIssue), .memWrValid(memWrValid), .strb(strb),
    .armedQ(armedQ), .wbQ(wbQ), .busy(statusBusy), .wbOut(wbOut)
  );

  ecc_inj_datapath #(
    .CTRL_W(CTRL_W), .CHK_W(CHK_W), .PAT_LSB(PAT_LSB)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlWrData(ctrlWrData),
    .chkIn(chkIn), .chkOut(chkOut), .patQ(patQ)
  );

  always_comb begin
    ctrlRdData = '0;
    ctrlRdData[PAT_LSB +: CHK_W] = patQ;
    ctrlRdData[WB_BIT]   = wbQ;
    ctrlRdData[TRIG_BIT] = armedQ;
  end
endmodule

// File: rtl/ecc_inj_checker.sv
module ecc_inj_checker #(
  parameter int CHK_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             memWrValid,
  input logic             wrIssue,
  input logic [CHK_W-1:0] chkIn,
  input logic [CHK_W-1:0] chkOut,
  input logic             wbOut,
  input logic             statusBusy,
  input logic             armedQ,
  input logic [CHK_W-1:0] patQ
);
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (chkOut == chkIn));

  assert_selfclear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && memWrValid) |=> !armedQ);

  assert_mask_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !memWrValid) |=> ($stable(patQ) && armedQ));

  assert_wb_only_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbOut |-> (memWrValid && armedQ));

  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBusy) |-> $past(wrIssue));
endmodule

bind ecc_inj_top ecc_inj_checker #(.CHK_W(CHK_W)) uChk (
  .clk(clk), .rstN(rstN), .memWrValid(memWrValid), .wrIssue(wrIssue),
  .chkIn(chkIn), .chkOut(chkOut), .wbOut(wbOut), .statusBusy(statusBusy),
  .armedQ(armedQ), .patQ(patQ)
);

// File: tb/ecc_inj_top_test.sv
module ecc_inj_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [31:0] ctrlRdData;
  logic        wrIssue = 1'b0;
  logic        memWrValid = 1'b0;
  logic [7:0]  chkIn = '0;
  logic [7:0]  chkOut;
  logic        wbOut;
  logic        statusBusy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ecc_inj_top uut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .wrIssue(wrIssue), .memWrValid(memWrValid),
    .chkIn(chkIn), .chkOut(chkOut), .wbOut(wbOut), .statusBusy(statusBusy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // {ctrlWr, ctrlData[31:0], memWr, chkIn[7:0], expChk[7:0], expWb}
  localparam int NV = 11;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 1'b1, 8'h5A, 8'h5A, 1'b0},  // R2 idle pass
    {1'b1, 32'h01F4_0100, 1'b0, 8'h11, 8'h11, 1'b0},  // R3 arm, data syndrome
    {1'b0, 32'h0000_0000, 1'b1, 8'h11, 8'hE5, 1'b1},  // R4 R7 injected
    {1'b0, 32'h0000_0000, 1'b1, 8'h11, 8'h11, 1'b0},  // R5 disarmed
    {1'b1, 32'h0003_0100, 1'b1, 8'h80, 8'h80, 1'b0},  // R9 arm+write same cycle
    {1'b1, 32'h01FF_0000, 1'b0, 8'h22, 8'h22, 1'b0},  // R6 ignored while armed
    {1'b0, 32'h0000_0000, 1'b1, 8'h80, 8'h83, 1'b0},  // R6 R7 mask 0x03, no wb
    {1'b1, 32'h0080_0000, 1'b1, 8'h01, 8'h01, 1'b0},  // R10 no trigger
    {1'b0, 32'h0000_0000, 1'b1, 8'h01, 8'h01, 1'b0},  // R10 still clean
    {1'b1, 32'h0080_0100, 1'b0, 8'h00, 8'h00, 1'b0},  // R3 check-bit 7 mask
    {1'b0, 32'h0000_0000, 1'b1, 8'h00, 8'h80, 1'b0}   // R4 check-bit flip
  };

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(ctrlRdData == 32'h0, "R1 readback", ctrlRdData, 32'h0);
    check(statusBusy == 1'b0, "R1 busy", {31'b0, statusBusy}, 32'h0);
    chkIn = 8'h3C;
    #1;
    check(chkOut == 8'h3C, "R1 pass", {24'b0, chkOut}, 32'h3C);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ctrlWrEn   = VEC[i][50];
      ctrlWrData = VEC[i][49:18];
      memWrValid = VEC[i][17];
      chkIn      = VEC[i][16:9];
      #1;
      check(chkOut == VEC[i][8:1], $sformatf("R4/R2 vec%0d chkOut", i),
            {24'b0, chkOut}, {24'b0, VEC[i][8:1]});
      check(wbOut == VEC[i][0], $sformatf("R7 vec%0d wbOut", i),
            {31'b0, wbOut}, {31'b0, VEC[i][0]});
    end
    @(negedge clk);
    ctrlWrEn = 1'b0; memWrValid = 1'b0;

    // R3 readback of an armed configuration
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = 32'h01F4_0100;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    #1;
    check(ctrlRdData == 32'h01F4_0100, "R3 readback", ctrlRdData, 32'h01F4_0100);
    // R6 control write while armed is dropped
    ctrlWrEn = 1'b1; ctrlWrData = 32'h0055_0000;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    #1;
    check(ctrlRdData == 32'h01F4_0100, "R6 readback", ctrlRdData, 32'h01F4_0100);
    // R6 control write coinciding with the injected write is dropped too
    ctrlWrEn = 1'b1; ctrlWrData = 32'h0055_0100; memWrValid = 1'b1; chkIn = 8'h00;
    #1;
    check(chkOut == 8'hF4, "R4 inject", {24'b0, chkOut}, 32'hF4);
    @(negedge clk);
    ctrlWrEn = 1'b0; memWrValid = 1'b0;
    #1;
    check(ctrlRdData == 32'h01F4_0000, "R5 R6 self-clear", ctrlRdData, 32'h01F4_0000);

    // R8 pending-write tracking
    wrIssue = 1'b1;
    @(negedge clk);
    wrIssue = 1'b0;
    #1;
    check(statusBusy == 1'b1, "R8 busy set", {31'b0, statusBusy}, 32'h1);
    wrIssue = 1'b1; memWrValid = 1'b1;
    @(negedge clk);
    wrIssue = 1'b0; memWrValid = 1'b0;
    #1;
    check(statusBusy == 1'b1, "R8 busy hold", {31'b0, statusBusy}, 32'h1);
    memWrValid = 1'b1;
    @(negedge clk);
    memWrValid = 1'b0;
    #1;
    check(statusBusy == 1'b0, "R8 busy clear", {31'b0, statusBusy}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule